// File: doc/BRIEF.md
# Packed SIMD Lane Add/Subtract Unit

This unit adds or subtracts two register words lane by lane. The lane width and the signedness are not set by the opcode. They come from the range that the 5-bit register specifiers fall into. A 2-bit mode field moves the same add or subtract between modular and clamping behaviour. A separate halving select returns the exact sum or difference divided by two.

The unit processes every lane that fits in the word. It ignores any configured vector length. A 32-bit word therefore holds four 8-bit lanes or two 16-bit lanes. An issuing pipeline stage presents one operation per cycle, qualified by a valid strobe. It receives the registered result, a saturation indicator and an illegal-encoding indicator one cycle later.

Top module: `packed_simd_addsub`

## Requirements
- R1: Specifier values select the lane type. Values 0..7 are signed 8-bit, 8..15 are unsigned 8-bit, 16..23 are signed 16-bit and 24..29 are unsigned 16-bit. Bit 4 of the specifier is the size bit (1 = 16-bit) and bit 3 is the unsigned bit.
- R2: All WORD_W/8 (8-bit) or WORD_W/16 (16-bit) lanes are computed independently. Lane i occupies bits [i*L +: L], and no carry crosses a lane boundary.
- R3: With mode 00 and halving off, each lane returns (a ± b) mod 2^L. Signedness does not affect the result.
- R4: With mode 01 on a signed range, a lane whose exact result exceeds 2^(L-1)-1 returns that value. A lane whose exact result is below -2^(L-1) returns -2^(L-1).
- R5: With mode 01 on an unsigned range, a lane whose exact result exceeds 2^L-1 returns all ones. A lane whose exact result is negative returns zero.
- R6: With halving on and mode 00, each lane returns the low L bits of floor((a ± b)/2). The exact value is taken signed or unsigned according to the range.
- R7: The saturation flag is high exactly when a legal mode-01 operation clamped at least one lane.
- R8: The illegal flag is raised, the result is zero and the saturation flag is low when any of the following holds: the three specifiers are not all in the same type range; any specifier is 30 or 31; the mode is 10 or 11; halving is requested with a mode other than 00.
- R9: Each accepted input produces outValid exactly one cycle later. The flags are low whenever outValid is low.
- R10: While reset is asserted, outValid, the result and both flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| isSub | input | 1 | 1 = subtract, 0 = add |
| halve | input | 1 | Halving select |
| mode | input | 2 | 00 wrap, 01 saturate, others illegal |
| dstSpec | input | 5 | Destination register specifier |
| srcASpec | input | 5 | First source register specifier |
| srcBSpec | input | 5 | Second source register specifier |
| opA | input | WORD_W | First operand word |
| opB | input | WORD_W | Second operand word |
| outValid | output | 1 | Result present |
| result | output | WORD_W | Packed lane results |
| satFlag | output | 1 | At least one lane clamped |
| illegalFlag | output | 1 | Specifier or mode combination rejected |

## Verification
Every result, both flags and outValid are due on the clock edge after the edge that captures inValid. The bench drives inputs on the falling edge and samples on the next falling edge. Each expected item records the cycle count at which it was issued, and the monitor requires that count plus one when the item appears. Issuing operations back to back and then going idle confirms that every output arrives in that single cycle and that nothing is left pending.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

  localparam int SPEC_W = 5;
  localparam logic [SPEC_W-1:0] SPEC_LIMIT = 5'd30;
  localparam logic [1:0] MODE_WRAP = 2'b00;
  localparam logic [1:0] MODE_SAT  = 2'b01;

  typedef enum logic [1:0] {
    CLS_S8  = 2'd0,
    CLS_U8  = 2'd1,
    CLS_S16 = 2'd2,
    CLS_U16 = 2'd3
  } laneClass_e;

  typedef struct packed {
    logic wide;
    logic signedOp;
    logic subtract;
    logic saturate;
    logic halve;
    logic illegal;
  } strobes_t;

endpackage

// File: rtl/psimd_lane.sv
module psimd_lane #(
  parameter int L = 8
) (
  input  logic [L-1:0] a,
  input  logic [L-1:0] b,
  input  logic         signedOp,
  input  logic         subtract,
  input  logic         saturate,
  input  logic         halve,
  output logic [L-1:0] y,
  output logic         clamped
);
  localparam int XW = L + 2;

  logic signed [XW-1:0] extA, extB, exact, maxV, minV;
  logic over, under;

  always_comb begin
    extA  = {{2{signedOp & a[L-1]}}, a};
    extB  = {{2{signedOp & b[L-1]}}, b};
    exact = subtract ? (extA - extB) : (extA + extB);
    maxV  = signedOp ? {3'b000, {(L-1){1'b1}}} : {2'b00, {L{1'b1}}};
    minV  = signedOp ? {3'b111, {(L-1){1'b0}}} : '0;
    over  = exact > maxV;
    under = exact < minV;
    clamped = saturate & (over | under);
    if (halve)                 y = exact[L:1];
    else if (saturate && over) y = maxV[L-1:0];
    else if (saturate && under) y = minV[L-1:0];
    else                       y = exact[L-1:0];
  end
endmodule

// File: rtl/psimd_ctrl.sv
module psimd_ctrl
  import psimd_pkg::*;
(
  input  logic              isSub,
  input  logic              halve,
  input  logic [1:0]        mode,
  input  logic [SPEC_W-1:0] dstSpec,
  input  logic [SPEC_W-1:0] srcASpec,
  input  logic [SPEC_W-1:0] srcBSpec,
  output strobes_t          strb
);
  laneClass_e dstCls, aCls, bCls;
  logic classMismatch, reservedSpec, modeBad;

  always_comb begin
    dstCls = laneClass_e'(dstSpec[4:3]);
    aCls   = laneClass_e'(srcASpec[4:3]);
    bCls   = laneClass_e'(srcBSpec[4:3]);
    classMismatch = (dstCls != aCls) || (dstCls != bCls);
    reservedSpec  = (dstSpec >= SPEC_LIMIT) || (srcASpec >= SPEC_LIMIT) ||
                    (srcBSpec >= SPEC_LIMIT);
    modeBad = mode[1] || (halve && (mode != MODE_WRAP));

    strb.wide     = (dstCls == CLS_S16) || (dstCls == CLS_U16);
    strb.signedOp = (dstCls == CLS_S8) || (dstCls == CLS_S16);
    strb.subtract = isSub;
    strb.saturate = (mode == MODE_SAT) && !halve;
    strb.halve    = halve;
    strb.illegal  = classMismatch || reservedSpec || modeBad;
  end
endmodule

// File: rtl/psimd_datapath.sv
module psimd_datapath
  import psimd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  strobes_t          strb,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              satFlag,
  output logic              illegalFlag
);
  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;

  logic [WORD_W-1:0] res8, res16, picked;
  logic [N8-1:0]     clamp8;
  logic [N16-1:0]    clamp16;
  logic              anyClamp;

  for (genvar g = 0; g < N8; g++) begin : gLane8
    psimd_lane #(.L(8)) uLane (
      .a(opA[g*8 +: 8]), .b(opB[g*8 +: 8]),
      .signedOp(strb.signedOp), .subtract(strb.subtract),
      .saturate(strb.saturate), .halve(strb.halve),
      .y(res8[g*8 +: 8]), .clamped(clamp8[g])
    );
  end

  for (genvar g = 0; g < N16; g++) begin : gLane16
    psimd_lane #(.L(16)) uLane (
      .a(opA[g*16 +: 16]), .b(opB[g*16 +: 16]),
      .signedOp(strb.signedOp), .subtract(strb.subtract),
      .saturate(strb.saturate), .halve(strb.halve),
      .y(res16[g*16 +: 16]), .clamped(clamp16[g])
    );
  end

  always_comb begin
    picked   = strb.wide ? res16 : res8;
    anyClamp = strb.wide ? (|clamp16) : (|clamp8);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      result      <= '0;
      satFlag     <= 1'b0;
      illegalFlag <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result      <= strb.illegal ? '0 : picked;
        satFlag     <= !strb.illegal && anyClamp;
        illegalFlag <= strb.illegal;
      end else begin
        satFlag     <= 1'b0;
        illegalFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/packed_simd_addsub.sv
module packed_simd_addsub
  import psimd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              isSub,
  input  logic              halve,
  input  logic [1:0]        mode,
  input  logic [4:0]        dstSpec,
  input  logic [4:0]        srcASpec,
  input  logic [4:0]        srcBSpec,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              satFlag,
  output logic              illegalFlag
);
  strobes_t strb;

  psimd_ctrl uCtrl (
    .isSub(isSub), .halve(halve), .mode(mode),
    .dstSpec(dstSpec), .srcASpec(srcASpec), .srcBSpec(srcBSpec),
    .strb(strb)
  );

  psimd_datapath #(.WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb),
    .opA(opA), .opB(opB),
    .outValid(outValid), .result(result),
    .satFlag(satFlag), .illegalFlag(illegalFlag)
  );
endmodule

// File: rtl/psimd_checker.sv
module psimd_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              halve,
  input logic [1:0]        mode,
  input logic              outValid,
  input logic [WORD_W-1:0] result,
  input logic              satFlag,
  input logic              illegalFlag
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_quiet_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!satFlag && !illegalFlag));

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegalFlag |-> (result == '0 && !satFlag));

  assert_bad_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (mode[1] || (halve && mode != 2'b00))) |=> illegalFlag);

  assert_sat_needs_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (mode != 2'b01 || halve)) |=> !satFlag);
endmodule

bind packed_simd_addsub psimd_checker #(.WORD_W(WORD_W)) uChecker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .halve(halve), .mode(mode),
  .outValid(outValid), .result(result), .satFlag(satFlag),
  .illegalFlag(illegalFlag)
);

// File: tb/test_packed_simd_addsub.sv
`timescale 1ns/1ps
module test_packed_simd_addsub;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    bit           sat;
    bit           ill;
    int           issue;
    string        tag;
  } item_t;

  logic clk = 0, rstN = 0, inValid = 0, isSub = 0, halve = 0;
  logic [1:0] mode = 0;
  logic [4:0] dstSpec = 0, srcASpec = 0, srcBSpec = 0;
  logic [W-1:0] opA = 0, opB = 0;
  logic outValid, satFlag, illegalFlag;
  logic [W-1:0] result;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  packed_simd_addsub #(.WORD_W(W)) i_packed_simd_addsub (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isSub(isSub), .halve(halve),
    .mode(mode), .dstSpec(dstSpec), .srcASpec(srcASpec), .srcBSpec(srcBSpec),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .satFlag(satFlag), .illegalFlag(illegalFlag)
  );

  function automatic item_t model(bit sub, bit hv, bit [1:0] md,
                                  bit [4:0] d, bit [4:0] sa, bit [4:0] sbs,
                                  bit [W-1:0] x, bit [W-1:0] y);
    item_t it;
    int L, n, hi, lo, av, bv, e, r;
    bit sg;
    it.res = '0; it.sat = 0; it.ill = 0;
    if (d >= 30 || sa >= 30 || sbs >= 30 || d[4:3] != sa[4:3] ||
        d[4:3] != sbs[4:3] || md[1] || (hv && md != 0)) begin
      it.ill = 1;
      return it;
    end
    L  = d[4] ? 16 : 8;
    sg = !d[3];
    n  = W / L;
    hi = sg ? (1 << (L-1)) - 1 : (1 << L) - 1;
    lo = sg ? -(1 << (L-1)) : 0;
    for (int i = 0; i < n; i++) begin
      av = 0; bv = 0;
      for (int k = 0; k < L; k++) begin
        if (x[i*L+k]) av += (1 << k);
        if (y[i*L+k]) bv += (1 << k);
      end
      if (sg && av >= (1 << (L-1))) av -= (1 << L);
      if (sg && bv >= (1 << (L-1))) bv -= (1 << L);
      e = sub ? av - bv : av + bv;
      if (hv) r = e >>> 1;
      else if (md == 2'b01 && e > hi) begin r = hi; it.sat = 1; end
      else if (md == 2'b01 && e < lo) begin r = lo; it.sat = 1; end
      else r = e;
      for (int k = 0; k < L; k++) it.res[i*L+k] = r[k];
    end
    return it;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [W-1:0] act,
                       logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(string tag, bit sub, bit hv, bit [1:0] md,
                       bit [4:0] d, bit [4:0] sa, bit [4:0] sbs,
                       bit [W-1:0] x, bit [W-1:0] y);
    item_t it;
    @(negedge clk);
    inValid = 1; isSub = sub; halve = hv; mode = md;
    dstSpec = d; srcASpec = sa; srcBSpec = sbs; opA = x; opB = y;
    it = model(sub, hv, md, d, sa, sbs, x, y);
    it.issue = cyc;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 0;
    end
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        check(0, "R9", "unexpected outValid", W'(1), W'(0));
      end else begin
        item_t it;
        it = sb.pop_front();
        check(result == it.res && satFlag == it.sat && illegalFlag == it.ill,
              it.tag, "result/sat/illegal",
              {result[W-1:2], satFlag, illegalFlag},
              {it.res[W-1:2], it.sat, it.ill});
        if (result != it.res)
          $display("  detail %s: result=%h expected=%h", it.tag, result, it.res);
        check(cyc == it.issue + 1, "R9", "latency", W'(cyc), W'(it.issue + 1));
      end
    end else if (rstN && (satFlag || illegalFlag)) begin
      check(0, "R9", "flags while outValid low",
            {30'b0, satFlag, illegalFlag}, W'(0));
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    lf = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(outValid == 0 && result == '0 && satFlag == 0 && illegalFlag == 0,
          "R10", "reset state", result, W'(0));
    rstN = 1;

    // R3 / R1: signed 8-bit wrap add, carries stay inside lanes (R2)
    drive("R3", 0, 0, 2'b00, 5'd2, 5'd3, 5'd4, 32'h7F01_FF80, 32'h0101_0180);
    // R3: unsigned 16-bit wrap subtract
    drive("R3", 1, 0, 2'b00, 5'd24, 5'd25, 5'd29, 32'h0000_1234, 32'h0001_0235);
    // R4: signed 8-bit saturate, positive and negative clamps
    drive("R4", 0, 0, 2'b01, 5'd1, 5'd5, 5'd7, 32'h7F80_1040, 32'h01FF_2040);
    // R4: signed 16-bit saturate subtract
    drive("R4", 1, 0, 2'b01, 5'd16, 5'd20, 5'd23, 32'h8000_7FFF, 32'h0001_FFFF);
    // R5: unsigned 8-bit saturating add to all ones
    drive("R5", 0, 0, 2'b01, 5'd8, 5'd9, 5'd15, 32'hF0FF_1000, 32'h2001_0FFF);
    // R5: unsigned 8-bit saturating subtract to zero
    drive("R5", 1, 0, 2'b01, 5'd10, 5'd11, 5'd12, 32'h0510_FF00, 32'h0620_0101);
    // R7: saturating mode with no clamp
    drive("R7", 0, 0, 2'b01, 5'd8, 5'd8, 5'd8, 32'h0102_0304, 32'h1010_1010);
    // R6: unsigned 16-bit halving add keeps the carry bit
    drive("R6", 0, 1, 2'b00, 5'd26, 5'd27, 5'd28, 32'hFFFF_0001, 32'hFFFF_0002);
    // R6: signed 16-bit halving subtract, odd negative floors
    drive("R6", 1, 1, 2'b00, 5'd17, 5'd18, 5'd19, 32'h8000_0001, 32'h7FFF_0004);
    // R6: signed 8-bit halving add
    drive("R6", 0, 1, 2'b00, 5'd0, 5'd6, 5'd7, 32'h80FF_7F03, 32'h80FF_7F04);
    // R6: unsigned 8-bit halving subtract
    drive("R6", 1, 1, 2'b00, 5'd13, 5'd14, 5'd15, 32'h0003_FF10, 32'h0104_0020);
    idle(2);
    // R8: mismatched ranges, reserved specifier, bad modes
    drive("R8", 0, 0, 2'b00, 5'd2, 5'd9, 5'd2, 32'h1111_1111, 32'h2222_2222);
    drive("R8", 0, 0, 2'b00, 5'd30, 5'd30, 5'd30, 32'h1111_1111, 32'h2222_2222);
    drive("R8", 0, 0, 2'b01, 5'd24, 5'd24, 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive("R8", 0, 1, 2'b01, 5'd16, 5'd16, 5'd16, 32'h1111_1111, 32'h2222_2222);
    drive("R8", 1, 0, 2'b10, 5'd8, 5'd8, 5'd8, 32'h1111_1111, 32'h2222_2222);
    drive("R8", 1, 0, 2'b11, 5'd8, 5'd8, 5'd8, 32'h1111_1111, 32'h2222_2222);
    // R1: same operands in each of the four ranges
    drive("R1", 0, 0, 2'b01, 5'd3, 5'd3, 5'd3, 32'h80F0_7F7F, 32'h80F0_0101);
    drive("R1", 0, 0, 2'b01, 5'd11, 5'd11, 5'd11, 32'h80F0_7F7F, 32'h80F0_0101);
    drive("R1", 0, 0, 2'b01, 5'd21, 5'd21, 5'd21, 32'h80F0_7F7F, 32'h80F0_0101);
    drive("R1", 0, 0, 2'b01, 5'd29, 5'd29, 5'd29, 32'h80F0_7F7F, 32'h80F0_0101);
    // R2: pseudo-random sweep over legal encodings
    for (int i = 0; i < 60; i++) begin
      bit [31:0] x, y;
      bit [4:0] base, s;
      bit hv;
      bit [1:0] md;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} * 32'd1103515245 + 32'd12345;
      x = lf;
      lf = lf * 32'd1103515245 + 32'd12345;
      y = lf;
      base = 5'(lf[31:30]) << 3;
      s = base + 5'(lf[17:15] % 3'd6);
      hv = lf[20];
      md = hv ? 2'b00 : {1'b0, lf[21]};
      drive("R2", lf[22], hv, md, s, base + 5'(lf[11:10] % 2'd3), s, x, y);
      if (lf[5:4] == 0) idle(1);
    end
    idle(3);
    check(sb.size() == 0, "R9", "pending items at end", W'(sb.size()), W'(0));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule